// File: doc/BRIEF.md
# Serial Port Register Front End with Transmit Holding Buffer

This block sits between a processor write port and a bit-level serial shifter. It holds three programmable registers and a one-byte transmit holding buffer. The processor writes one of four targets through a single write port, selected by `wr_sel`:

- 0: the control register
- 1: the receiver status register
- 2: the transmitter status register
- 3: the transmit data byte

The control register is decoded into a frame description that the serializer consumes. The description gives the number of data bits, the start bit, the stop length counted in half bits, parity enable and polarity, a divide-by-16 clock flag, and a synchronous flag. Every control write also pulses a restart request toward the receiver shifter.

The transmit side tracks one pending byte. It hands that byte to the shifter with a single-cycle load strobe as soon as three things hold at once: the transmitter is enabled, a byte is pending, and the shifter reports that it is empty. The shifter itself is represented only by its `shift_empty` input. The transmitter status register keeps three hardware-owned flags that processor writes cannot overwrite directly:

- buffer empty (bit 7)
- underrun (bit 6)
- end of transmission (bit 4)

Top module: `ser_frontend`

## Requirements
- R1: Control register bits 6:5 (written with wr_sel=0) set `word_bits` one cycle after the write: 00 gives 8, 01 gives 7, 10 gives 6 and 11 gives 5.
- R2: Control bits 4:3 set the framing. 00 is synchronous: `start_bits`=0, `stop_halves`=0, `sync_mode`=1. 01 gives one start and `stop_halves`=2. 10 gives one start and `stop_halves`=3. 11 gives one start and `stop_halves`=4. `sync_mode` is 0 for all three asynchronous codes.
- R3: Control bit 2 drives `par_en`, control bit 1 drives `par_even` (1 even, 0 odd), and control bit 7 drives `div16`.
- R4: Every control write makes `rx_restart` high for exactly the one cycle after the write.
- R5: A receiver status write (wr_sel=1) clears the whole register when data bit 0 is 0. Otherwise it stores data AND 0x0B.
- R6: A transmitter status write (wr_sel=2) leaves bits 7, 6 and 4 at their previous values and copies every other bit from the data. Bit 0 is the transmitter enable.
- R7: A transmitter status write with bit 0 = 0 clears bit 6. It sets bit 4 when `shift_empty` is 1 in that cycle and otherwise leaves bit 4 unchanged.
- R8: A transmitter status write with bit 0 = 1 clears bit 4. If a byte is pending and `shift_empty` is 1, that byte is loaded in the same cycle. Bit 7 is then set if no byte remains pending, and otherwise keeps its previous value.
- R9: A data write (wr_sel=3) stores the byte, marks it pending and clears bit 7. If the transmitter is enabled and `shift_empty` is 1, the byte is loaded at once: bit 7 ends at 1 and nothing stays pending.
- R10: On a cycle with no write to wr_sel 2 or 3, an enabled transmitter with a pending byte and `shift_empty`=1 loads the byte and sets bit 7. A load raises `load_stb` for one cycle, with `load_data` showing the byte.
- R11: On a cycle with no write to wr_sel 2 or 3, a rising edge of `shift_empty` while the transmitter is enabled and nothing is pending sets bit 6 (underrun).
- R12: After reset:
  - the transmitter status reads 0x80 and no byte is pending;
  - the receiver status reads 0;
  - the frame outputs match control value 0;
  - `rx_restart` and `load_stb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 receiver status, 2 transmitter status, 3 data |
| wr_data | input | 8 | Write data |
| shift_empty | input | 1 | Serializer reports its shift register is empty |
| rx_stat | output | 8 | Receiver status register |
| tx_stat | output | 8 | Transmitter status register |
| word_bits | output | 4 | Data bits per character (5 to 8) |
| start_bits | output | 1 | One start bit when 1 |
| stop_halves | output | 3 | Stop length in half bits (0, 2, 3, 4) |
| par_en | output | 1 | Parity enabled |
| par_even | output | 1 | Even parity when 1 |
| div16 | output | 1 | Bit clock divided by 16 |
| sync_mode | output | 1 | Synchronous framing, no start or stop |
| rx_restart | output | 1 | One-cycle receiver restart request |
| load_stb | output | 1 | One-cycle load of the shifter |
| load_data | output | 8 | Byte handed to the shifter |

## Verification
All 256 control values and all 256 receiver status values are swept, with the expected fields computed arithmetically. A wrong field slice or an off-by-one stop encoding would show up at the affected values. The transmit sequence targets the following cases:

- A status write of 0xFF whose protected bits must not stick. A design that copied them would report a false empty buffer or underrun.
- An enable that arrives while the shifter is busy, which must not load.
- A disable while the shifter is busy, which must leave end-of-transmission unset.
- A shifter that runs dry with a byte still pending, which must load rather than flag an underrun.
- A shifter that runs dry with nothing pending, which must flag an underrun that a later enable write keeps.

// File: rtl/ser_fe_pkg.sv
package ser_fe_pkg;
  localparam int unsigned REG_W = 8;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_RXS  = 2'd1,
    SEL_TXS  = 2'd2,
    SEL_DATA = 2'd3
  } wsel_e;

  // control register field positions
  localparam int unsigned CT_DIV16    = 7;
  localparam int unsigned CT_WL_LO    = 5;
  localparam int unsigned CT_FR_LO    = 3;
  localparam int unsigned CT_PAR_EN   = 2;
  localparam int unsigned CT_PAR_EVEN = 1;

  // receiver status
  localparam int unsigned RX_EN = 0;
  localparam logic [REG_W-1:0] RX_KEEP_MASK = 8'h0B;

  // transmitter status
  localparam int unsigned TX_EN  = 0;
  localparam int unsigned TX_EOT = 4;
  localparam int unsigned TX_UE  = 6;
  localparam int unsigned TX_BE  = 7;
  localparam logic [REG_W-1:0] TX_RO_MASK =
    (REG_W'(1) << TX_BE) | (REG_W'(1) << TX_UE) | (REG_W'(1) << TX_EOT);
  localparam logic [REG_W-1:0] TX_RESET = REG_W'(1) << TX_BE;

  localparam int unsigned MAX_WORD = 8;

  typedef struct packed {
    logic [3:0] word_bits;
    logic       start_bit;
    logic [2:0] stop_halves;
    logic       par_en;
    logic       par_even;
    logic       div16;
    logic       sync_mode;
  } frame_cfg_t;

  function automatic frame_cfg_t decode_ctrl(input logic [REG_W-1:0] c);
    frame_cfg_t f;
    logic [1:0] wl;
    logic [1:0] fr;
    wl = c[CT_WL_LO +: 2];
    fr = c[CT_FR_LO +: 2];
    f.word_bits = 4'(MAX_WORD) - {2'b00, wl};
    f.par_en    = c[CT_PAR_EN];
    f.par_even  = c[CT_PAR_EVEN];
    f.div16     = c[CT_DIV16];
    case (fr)
      2'd0: begin f.start_bit = 1'b0; f.stop_halves = 3'd0; f.sync_mode = 1'b1; end
      2'd1: begin f.start_bit = 1'b1; f.stop_halves = 3'd2; f.sync_mode = 1'b0; end
      2'd2: begin f.start_bit = 1'b1; f.stop_halves = 3'd3; f.sync_mode = 1'b0; end
      default: begin f.start_bit = 1'b1; f.stop_halves = 3'd4; f.sync_mode = 1'b0; end
    endcase
    return f;
  endfunction
endpackage

// File: rtl/ser_fe_frame_dec.sv
module ser_fe_frame_dec
  import ser_fe_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output frame_cfg_t       cfg,
  output logic             restart
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg     <= decode_ctrl('0);
      restart <= 1'b0;
    end else begin
      restart <= wr;
      if (wr) cfg <= decode_ctrl(wdata);
    end
  end
endmodule

// File: rtl/ser_fe_rx_stat.sv
module ser_fe_rx_stat
  import ser_fe_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] stat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
    end else if (wr) begin
      if (!wdata[RX_EN]) stat <= '0;
      else               stat <= wdata & RX_KEEP_MASK;
    end
  end
endmodule

// File: rtl/ser_fe_tx_buf.sv
module ser_fe_tx_buf
  import ser_fe_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_stat,
  input  logic             wr_dat,
  input  logic [REG_W-1:0] wdata,
  input  logic             shift_empty,
  output logic [REG_W-1:0] stat,
  output logic             load_stb,
  output logic [REG_W-1:0] load_data
);
  logic [REG_W-1:0] stat_n, hold_q, hold_n, ldd_n;
  logic             pend_q, pend_n, ld_n, se_d_q;

  always_comb begin
    stat_n = stat;
    pend_n = pend_q;
    hold_n = hold_q;
    ld_n   = 1'b0;
    ldd_n  = load_data;
    if (wr_stat) begin
      stat_n = (wdata & ~TX_RO_MASK) | (stat & TX_RO_MASK);
      if (!wdata[TX_EN]) begin
        stat_n[TX_UE] = 1'b0;
        if (shift_empty) stat_n[TX_EOT] = 1'b1;
      end else begin
        stat_n[TX_EOT] = 1'b0;
        if (pend_q && shift_empty) begin
          ld_n   = 1'b1;
          ldd_n  = hold_q;
          pend_n = 1'b0;
        end
        if (!pend_n) stat_n[TX_BE] = 1'b1;
      end
    end else if (wr_dat) begin
      hold_n = wdata;
      if (stat[TX_EN] && shift_empty) begin
        ld_n          = 1'b1;
        ldd_n         = wdata;
        pend_n        = 1'b0;
        stat_n[TX_BE] = 1'b1;
      end else begin
        pend_n        = 1'b1;
        stat_n[TX_BE] = 1'b0;
      end
    end else if (stat[TX_EN] && shift_empty) begin
      if (pend_q) begin
        ld_n          = 1'b1;
        ldd_n         = hold_q;
        pend_n        = 1'b0;
        stat_n[TX_BE] = 1'b1;
      end else if (!se_d_q) begin
        stat_n[TX_UE] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat      <= TX_RESET;
      pend_q    <= 1'b0;
      hold_q    <= '0;
      load_stb  <= 1'b0;
      load_data <= '0;
      se_d_q    <= 1'b1;
    end else begin
      stat      <= stat_n;
      pend_q    <= pend_n;
      hold_q    <= hold_n;
      load_stb  <= ld_n;
      load_data <= ldd_n;
      se_d_q    <= shift_empty;
    end
  end
endmodule

// File: rtl/ser_frontend.sv
module ser_frontend
  import ser_fe_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       shift_empty,
  output logic [7:0] rx_stat,
  output logic [7:0] tx_stat,
  output logic [3:0] word_bits,
  output logic       start_bits,
  output logic [2:0] stop_halves,
  output logic       par_en,
  output logic       par_even,
  output logic       div16,
  output logic       sync_mode,
  output logic       rx_restart,
  output logic       load_stb,
  output logic [7:0] load_data
);
  frame_cfg_t cfg;
  logic wr_ctl, wr_rxs, wr_txs, wr_dat;

  assign wr_ctl = wr_en && (wr_sel == SEL_CTRL);
  assign wr_rxs = wr_en && (wr_sel == SEL_RXS);
  assign wr_txs = wr_en && (wr_sel == SEL_TXS);
  assign wr_dat = wr_en && (wr_sel == SEL_DATA);

  ser_fe_frame_dec u_dec (
    .clk(clk), .rst(rst), .wr(wr_ctl), .wdata(wr_data),
    .cfg(cfg), .restart(rx_restart)
  );

  ser_fe_rx_stat u_rxs (
    .clk(clk), .rst(rst), .wr(wr_rxs), .wdata(wr_data), .stat(rx_stat)
  );

  ser_fe_tx_buf u_txb (
    .clk(clk), .rst(rst), .wr_stat(wr_txs), .wr_dat(wr_dat),
    .wdata(wr_data), .shift_empty(shift_empty), .stat(tx_stat),
    .load_stb(load_stb), .load_data(load_data)
  );

  assign word_bits   = cfg.word_bits;
  assign start_bits  = cfg.start_bit;
  assign stop_halves = cfg.stop_halves;
  assign par_en      = cfg.par_en;
  assign par_even    = cfg.par_even;
  assign div16       = cfg.div16;
  assign sync_mode   = cfg.sync_mode;
endmodule

// File: rtl/ser_frontend_chk.sv
module ser_frontend_chk
  import ser_fe_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic [7:0] wr_data,
  input logic       shift_empty,
  input logic [7:0] rx_stat,
  input logic [7:0] tx_stat,
  input logic [3:0] word_bits,
  input logic       start_bits,
  input logic [2:0] stop_halves,
  input logic       par_en,
  input logic       par_even,
  input logic       div16,
  input logic       sync_mode,
  input logic       rx_restart,
  input logic       load_stb,
  input logic [7:0] load_data
);
  logic txs_wr, dat_wr;
  assign txs_wr = wr_en && (wr_sel == SEL_TXS);
  assign dat_wr = wr_en && (wr_sel == SEL_DATA);

  AST_SYNC_NO_FRAMING: assert property (@(posedge clk) disable iff (rst)
    sync_mode |-> (!start_bits && stop_halves == 3'd0)); // R2
  AST_CTRL_RESTART: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_CTRL) |=> rx_restart); // R4
  AST_RX_MASKED: assert property (@(posedge clk) disable iff (rst)
    (rx_stat & ~RX_KEEP_MASK) == 8'h00); // R5
  AST_EN_KEEPS_UNDERRUN: assert property (@(posedge clk) disable iff (rst)
    (txs_wr && wr_data[TX_EN]) |=> (tx_stat[TX_UE] == $past(tx_stat[TX_UE]))); // R6
  AST_DIS_CLEARS_UNDERRUN: assert property (@(posedge clk) disable iff (rst)
    (txs_wr && !wr_data[TX_EN]) |=> !tx_stat[TX_UE]); // R7
  AST_EN_CLEARS_EOT: assert property (@(posedge clk) disable iff (rst)
    (txs_wr && wr_data[TX_EN]) |=> !tx_stat[TX_EOT]); // R8
  AST_BUSY_DATA_PENDS: assert property (@(posedge clk) disable iff (rst)
    (dat_wr && !shift_empty) |=> !tx_stat[TX_BE]); // R9
  AST_NO_LOAD_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    !shift_empty |=> !load_stb); // R10
endmodule

bind ser_frontend ser_frontend_chk u_chk (.*);

// File: tb/sim_ser_frontend.sv
`timescale 1ns/1ps
module sim_ser_frontend;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic       shift_empty = 1'b1;
  logic [7:0] rx_stat, tx_stat, load_data;
  logic [3:0] word_bits;
  logic [2:0] stop_halves;
  logic       start_bits, par_en, par_even, div16, sync_mode, rx_restart, load_stb;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  ser_frontend u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12 tx_stat", tx_stat, 8'h80);
    chk("R12 rx_stat", rx_stat, 0);
    chk("R12 frame", {word_bits, start_bits, stop_halves, par_en, par_even, div16, sync_mode},
        {4'd8, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1});
    chk("R12 strobes", {rx_restart, load_stb}, 0);

    // control sweep: R1 R2 R3 R4
    for (int c = 0; c < 256; c++) begin
      logic [7:0] cv;
      int fr;
      cv = 8'(c);
      fr = (c >> 3) & 3;
      wr(2'd0, cv);
      chk("R1 word_bits", word_bits, 8 - ((c >> 5) & 3));
      chk("R2 framing", {start_bits, stop_halves, sync_mode},
          {(fr != 0) ? 1'b1 : 1'b0, (fr == 0) ? 3'd0 : 3'(fr + 1), (fr == 0) ? 1'b1 : 1'b0});
      chk("R3 parity/div", {par_en, par_even, div16}, {cv[2], cv[1], cv[7]});
      chk("R4 restart high", rx_restart, 1);
    end
    @(negedge clk);
    chk("R4 restart one cycle", rx_restart, 0);

    // receiver status sweep: R5
    for (int d = 0; d < 256; d++) begin
      wr(2'd1, 8'(d));
      chk("R5 rx_stat", rx_stat, ((d & 1) != 0) ? (d & 8'h0B) : 0);
    end

    // transmit sequence
    wr(2'd3, 8'h5A);                       // disabled: pends
    chk("R9 data pends", tx_stat, 8'h00);
    chk("R9 no load disabled", load_stb, 0);
    wr(2'd2, 8'hFF);                       // protected bits ignored, enable loads
    chk("R6 protected bits kept", tx_stat & 8'h7F, 8'h2F);
    chk("R8 enable loads pending", {load_stb, load_data}, {1'b1, 8'h5A});
    chk("R8 BE set", tx_stat, 8'hAF);
    shift_empty = 1'b0;
    @(negedge clk);
    chk("R10 strobe one cycle", load_stb, 0);
    wr(2'd3, 8'h33);                       // busy: pends
    chk("R9 busy pends", {tx_stat, load_stb}, {8'h2F, 1'b0});
    idle(3);
    chk("R10 no load while busy", load_stb, 0);
    shift_empty = 1'b1;
    @(negedge clk);
    chk("R10 auto load", {load_stb, load_data}, {1'b1, 8'h33});
    chk("R10 BE set no underrun", tx_stat, 8'hAF);
    shift_empty = 1'b0;
    idle(4);
    shift_empty = 1'b1;
    @(negedge clk);
    chk("R11 underrun", tx_stat, 8'hEF);
    chk("R11 no load", load_stb, 0);
    wr(2'd2, 8'h2F);
    chk("R6 underrun survives enable write", tx_stat, 8'hEF);
    wr(2'd2, 8'h00);
    chk("R7 disable clr UE set EOT", tx_stat, 8'h90);
    shift_empty = 1'b0;
    wr(2'd2, 8'h01);
    chk("R8 enable clr EOT", tx_stat, 8'h81);
    wr(2'd2, 8'h04);
    chk("R7 busy disable no EOT", tx_stat, 8'h84);
    shift_empty = 1'b1;
    wr(2'd2, 8'h01);
    chk("R8 enable nothing pending", {tx_stat, load_stb}, {8'h81, 1'b0});
    wr(2'd3, 8'hC3);
    chk("R9 immediate load", {tx_stat, load_stb, load_data}, {8'h81, 1'b1, 8'hC3});
    wr(2'd2, 8'h00);
    chk("R7 disable empty", tx_stat, 8'h90);
    wr(2'd3, 8'h11);
    chk("R9 pend disabled", tx_stat, 8'h10);
    shift_empty = 1'b0;
    wr(2'd2, 8'h01);
    chk("R8 enable busy keeps BE", {tx_stat, load_stb}, {8'h01, 1'b0});
    shift_empty = 1'b1;
    @(negedge clk);
    chk("R10 load after busy", {tx_stat, load_stb, load_data}, {8'h81, 1'b1, 8'h11});
    summary();
  end
endmodule